// File: doc/BRIEF.md
# Tank Fill and Drain Step Sequencer

This block sequences a single tank through a fill-then-drain cycle. It sits idle until an operator presses a start button. It then opens the inlet valve and checks a level switch that reports a full tank. While the tank is not full, it alternates between a checking step and a holding step, with the inlet kept open. When the switch reports full, it closes the inlet, opens the outlet and returns to idle. The outlet stays open until the next start press.

Each process step has one flip-flop of its own, so the step register is one-hot: there are five steps, exactly one is active, and entering a step clears the one before it. Both valve drives come straight from flip-flops, which keeps glitches away from the actuators. The external reset is asynchronous and active low. Inside the block it is released in step with the clock.

Top module: `tank_seq_ctrl`

## Requirements
- R1: While reset is held, and on the first cycles after release, the idle step is active and both `inlet_valve` and `outlet_valve` are 0.
- R2: In the idle step, with `start_btn` low, the sequencer stays idle and the valves keep their values whatever `tank_full` does.
- R3: `start_btn` high at a rising edge while idle enters the open step at that edge: `inlet_valve` becomes 1 and `outlet_valve` becomes 0.
- R4: The open step always moves to the check step at the next edge, with `inlet_valve` still 1.
- R5: In the check step, `tank_full` high at an edge enters the drain step at that edge: `inlet_valve` becomes 0 and `outlet_valve` becomes 1.
- R6: In the check step, `tank_full` low at an edge enters the hold-fill step with `inlet_valve` 1. The hold-fill step returns to the check step at the next edge whatever `tank_full` is, so `tank_full` is acted on only in the check step.
- R7: The drain step returns to idle at the next edge, and `outlet_valve` stays 1 in idle until a start press clears it (R3).
- R8: `start_btn` has no effect in any step other than idle.
- R9: Exactly one step is active at all times, and `inlet_valve` and `outlet_valve` are never 1 together.
- R10: Both valve outputs change only at rising clock edges. A change of `tank_full` or `start_btn` between edges does not show on them until the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset; released inside the block in step with the clock |
| start_btn | input | 1 | Operator start request, sampled at each rising edge |
| tank_full | input | 1 | Level switch, 1 when the tank is full |
| inlet_valve | output | 1 | Registered drive for the fill valve, 1 = open |
| outlet_valve | output | 1 | Registered drive for the drain valve, 1 = open |

## Verification
The bench uses four patterns. In the first, the full switch is already high when start is pressed, which shows the shortest path of two edges from start to drain. In the second, the switch rises while the check step is active, and in the third it rises while the hold-fill step is active. The one-cycle difference in drain timing between these two shows that the check and hold-fill steps alternate as separate states. In the fourth, one-cycle pulses are applied: a full pulse during hold-fill, and start presses during fill and drain. These show that each input is acted on only in its own step. Idle stretches with the full switch high, and samples taken between edges, show that the outlet is held and that the outputs are registered.

// File: rtl/tank_seq_pkg.sv
package tank_seq_pkg;

  localparam int unsigned NUM_STEPS = 5;

  localparam int unsigned ST_IDLE  = 0;
  localparam int unsigned ST_OPEN  = 1;
  localparam int unsigned ST_CHECK = 2;
  localparam int unsigned ST_HOLD  = 3;
  localparam int unsigned ST_DRAIN = 4;

  typedef logic [NUM_STEPS-1:0] step_vec_t;

  localparam step_vec_t STEP_RESET = step_vec_t'(1) << ST_IDLE;

endpackage

// File: rtl/tank_rst_sync.sv
module tank_rst_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  localparam int unsigned LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[SYNC_STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = chain_q[LAST];

endmodule

// File: rtl/tank_step_next.sv
module tank_step_next
  import tank_seq_pkg::*;
(
  input  step_vec_t cur_step,
  input  logic      start_req,
  input  logic      full_lvl,
  output step_vec_t nxt_step
);

  logic      legal;
  step_vec_t raw;

  always_comb begin
    legal = ($countones(cur_step) == 1);

    raw            = '0;
    raw[ST_IDLE]   = (cur_step[ST_IDLE] & ~start_req) | cur_step[ST_DRAIN];
    raw[ST_OPEN]   = cur_step[ST_IDLE] & start_req;
    raw[ST_CHECK]  = cur_step[ST_OPEN] | cur_step[ST_HOLD];
    raw[ST_HOLD]   = cur_step[ST_CHECK] & ~full_lvl;
    raw[ST_DRAIN]  = cur_step[ST_CHECK] & full_lvl;

    nxt_step = legal ? raw : STEP_RESET;
  end

endmodule

// File: rtl/tank_step_reg.sv
module tank_step_reg
  import tank_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  step_vec_t nxt_step,
  output step_vec_t cur_step
);

  for (genvar i = 0; i < NUM_STEPS; i++) begin : g_bit
    localparam logic RST_VAL = STEP_RESET[i];
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cur_step[i] <= RST_VAL;
      end else begin
        cur_step[i] <= nxt_step[i];
      end
    end
  end

  p_one_step_active_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(cur_step));

  p_hold_returns_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cur_step[ST_HOLD] |=> cur_step[ST_CHECK]);

  p_open_advances_r4: assert property (@(posedge clk) disable iff (!rst_n)
    cur_step[ST_OPEN] |=> cur_step[ST_CHECK]);

  p_drain_to_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_step[ST_DRAIN] |=> cur_step[ST_IDLE]);

endmodule

// File: rtl/tank_valve_reg.sv
module tank_valve_reg
  import tank_seq_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  step_vec_t nxt_step,
  output logic      inlet_q,
  output logic      outlet_q
);

  logic inlet_d;
  logic outlet_en;
  logic outlet_d;

  always_comb begin
    inlet_d   = nxt_step[ST_OPEN] | nxt_step[ST_CHECK] | nxt_step[ST_HOLD];
    outlet_en = nxt_step[ST_OPEN] | nxt_step[ST_DRAIN];
    outlet_d  = nxt_step[ST_DRAIN];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inlet_q <= 1'b0;
    end else begin
      inlet_q <= inlet_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outlet_q <= 1'b0;
    end else if (outlet_en) begin
      outlet_q <= outlet_d;
    end
  end

  p_valves_exclusive_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(inlet_q && outlet_q));

endmodule

// File: rtl/tank_seq_ctrl.sv
module tank_seq_ctrl
  import tank_seq_pkg::*;
#(
  parameter int unsigned RST_SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_btn,
  input  logic tank_full,
  output logic inlet_valve,
  output logic outlet_valve
);

  logic      rst_sync_n;
  step_vec_t cur_step;
  step_vec_t nxt_step;

  tank_rst_sync #(
    .SYNC_STAGES(RST_SYNC_STAGES)
  ) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  tank_step_next u_next (
    .cur_step  (cur_step),
    .start_req (start_btn),
    .full_lvl  (tank_full),
    .nxt_step  (nxt_step)
  );

  tank_step_reg u_step (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .nxt_step (nxt_step),
    .cur_step (cur_step)
  );

  tank_valve_reg u_valve (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .nxt_step (nxt_step),
    .inlet_q  (inlet_valve),
    .outlet_q (outlet_valve)
  );

  p_start_opens_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_step[ST_IDLE] && start_btn) |=> (inlet_valve && !outlet_valve));

  p_full_drains_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_step[ST_CHECK] && tank_full) |=> (outlet_valve && !inlet_valve));

  p_idle_holds_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cur_step[ST_IDLE] && !start_btn) |=> ($stable(outlet_valve) && !inlet_valve));

  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cur_step[ST_IDLE] && start_btn) |=> !cur_step[ST_OPEN]);

endmodule

// File: tb/tank_seq_ctrl_tb.sv
module tank_seq_ctrl_tb;

  logic clk = 1'b0;
  logic rst_n;
  logic start_btn;
  logic tank_full;
  logic inlet_valve;
  logic outlet_valve;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #5 clk = ~clk;

  tank_seq_ctrl u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_btn    (start_btn),
    .tank_full    (tank_full),
    .inlet_valve  (inlet_valve),
    .outlet_valve (outlet_valve)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic expect_valves(input string req, input logic exp_in, input logic exp_out);
    n_vec++;
    if (inlet_valve !== exp_in || outlet_valve !== exp_out) begin
      n_bad++;
      $display("FAIL %s: inlet/outlet = %b/%b, expected %b/%b",
               req, inlet_valve, outlet_valve, exp_in, exp_out);
    end
  endtask

  // R1: reset state, during and after release
  task automatic t_reset();
    rst_n = 1'b0; start_btn = 1'b0; tank_full = 1'b0;
    repeat (3) @(negedge clk);
    expect_valves("R1 in reset", 1'b0, 1'b0);
    rst_n = 1'b1;
    repeat (4) tick();
    expect_valves("R1 after release", 1'b0, 1'b0);
  endtask

  // R2: idle without start, full switch toggling
  task automatic t_idle_quiet();
    tank_full = 1'b1;
    repeat (3) tick();
    expect_valves("R2 idle full high", 1'b0, 1'b0);
    tank_full = 1'b0;
    tick();
    expect_valves("R2 idle full low", 1'b0, 1'b0);
  endtask

  // Full already high at start: shortest path to drain
  task automatic t_full_at_start();
    tank_full = 1'b1;
    start_btn = 1'b1;
    tick();
    expect_valves("R3 start opens inlet", 1'b1, 1'b0);
    start_btn = 1'b0;
    tick();
    expect_valves("R4 open to check", 1'b1, 1'b0);
    tick();
    expect_valves("R5 check full drains", 1'b0, 1'b1);
    tick();
    expect_valves("R7 idle keeps outlet", 1'b0, 1'b1);
    repeat (3) tick();
    expect_valves("R7 outlet held in idle", 1'b0, 1'b1);
  endtask

  // Full rises while check is active; start presses ignored during fill
  task automatic t_full_in_check();
    tank_full = 1'b0;
    start_btn = 1'b1;
    tick();                                  // open
    expect_valves("R3 start clears outlet", 1'b1, 1'b0);
    start_btn = 1'b0;
    tick();                                  // check
    tick();                                  // hold
    expect_valves("R6 not full keeps filling", 1'b1, 1'b0);
    start_btn = 1'b1;
    tick();                                  // check
    tick();                                  // hold
    start_btn = 1'b0;
    expect_valves("R8 start ignored while filling", 1'b1, 1'b0);
    tick();                                  // check
    tank_full = 1'b1;
    #1;
    expect_valves("R10 no change between edges", 1'b1, 1'b0);
    tick();                                  // drain
    expect_valves("R5 drain one edge after full in check", 1'b0, 1'b1);
    start_btn = 1'b1;
    tick();                                  // idle (start seen in drain: ignored)
    start_btn = 1'b0;
    expect_valves("R8 start ignored in drain", 1'b0, 1'b1);
    tick();
    expect_valves("R7 back in idle", 1'b0, 1'b1);
  endtask

  // Full rises while hold is active, then a one-cycle full pulse in hold
  task automatic t_full_in_hold();
    tank_full = 1'b0;
    start_btn = 1'b1;
    tick();                                  // open
    start_btn = 1'b0;
    tick();                                  // check
    tick();                                  // hold
    tank_full = 1'b1;
    tick();                                  // check (hold ignores full)
    tank_full = 1'b0;
    expect_valves("R6 full pulse in hold ignored", 1'b1, 1'b0);
    tick();                                  // hold
    expect_valves("R6 still filling", 1'b1, 1'b0);
    tank_full = 1'b1;
    tick();                                  // check
    expect_valves("R6 hold returns to check first", 1'b1, 1'b0);
    tick();                                  // drain
    expect_valves("R5 drain after hold", 1'b0, 1'b1);
    tick();                                  // idle
    tank_full = 1'b0;
    start_btn = 1'b1;
    tick();                                  // open immediately from idle
    start_btn = 1'b0;
    expect_valves("R3 restart right after drain", 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not finish, actual hung, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_idle_quiet();
    t_full_at_start();
    t_full_in_check();
    t_full_in_hold();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule